// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

The block collects 32 level-sensitive interrupt lines and presents them to a primary controller in two ways. All lines, together with software-raised bits, are masked and folded into a single combined request. A fixed range of lines (21 to 30 by default) can also be sent on their own dedicated outputs, so the primary controller sees each of them as a separate source. An individual enable bit gates each dedicated output.

Software reaches the block through a plain 32-bit register bus. It has a valid strobe, a write flag, a 12-bit byte address and write data. The word index is the byte address shifted right by two, and the two lowest address bits are ignored. Writes take effect at the clock edge where the request is sampled. Read data and the error flag are registered and appear on the cycle after the request. The bus has no back-pressure: every request completes in one cycle and is never stalled. The level, mask, software and routing vectors all reset to zero.

Top module: `irq_aggregator`

## Requirements
- R1: The raw level vector samples `irq_in` on every clock, so a change on a line shows in the level vector one clock later. The effective level is the raw level OR the software bits.
- R2: `irq_combined` is high exactly when (effective level AND enable mask) is nonzero.
- R3: The register word index is `req_addr[11:2]`. Address bits 1:0 have no effect on which register is accessed.
- R4: Reads return data on `rsp_rdata` the cycle after the request. The readable words are: index 0, masked status (effective level AND mask); index 1, effective level; index 2, enable mask; index 4, software bits; index 8, routing enable vector.
- R5: A write to index 2 sets every mask bit that is 1 in the data. A write to index 3 clears every mask bit that is 1 in the data. Other mask bits keep their value.
- R6: A write to index 4 sets software bits where the data is 1. A write to index 5 clears them where the data is 1.
- R7: A write to index 8 ORs the data, ANDed with 0x7FE00000 (bits 21 to 30), into the routing enable vector. Bits outside 21 to 30 can never become 1.
- R8: A write to index 9 clears every routing enable bit that is 1 in the data.
- R9: `irq_direct[k]` carries the effective level of line 21+k while routing enable bit 21+k is set, and is low while that bit is clear. It follows a routing write on the cycle after that write.
- R10: After reset, every vector is zero, and `irq_combined`, `irq_direct` and `bus_err` are low.
- R11: A read of an index not listed in R4 returns zero. A write to an index not listed in R5 to R8 changes no state. Either kind of access raises `bus_err` for exactly the one cycle after the request. Mapped accesses leave `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| req_valid | input | 1 | Bus request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| irq_combined | output | 1 | Combined masked request to the primary controller |
| irq_direct | output | 10 | Routed lines 21 to 30, bit k is line 21+k |

## Verification
The bench sets a routing enable with all-ones data and checks that only bits 21 to 30 are kept. A design that forgets the 0x7FE00000 filter would read back stray enables. It raises lines 21 and 30 before enabling their routing and checks that the dedicated outputs stay low until the enable write. It then checks that a partial clear drops only the line that was cleared. A design that latched the level, or left outputs driven after the clear, would show the wrong pattern. It accesses registers through addresses with nonzero low bits, and it sends reads and writes to holes and to write-only words. A decoder that used the full byte address, or wrote to an aliased register, would fail the readback or the error-pulse checks. Software bits are checked against the status word, the combined request and a routed line, which would catch any path that dropped them.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Register word indices (byte address >> 2)
  localparam int IDX_STATUS   = 0;
  localparam int IDX_RAW      = 1;
  localparam int IDX_MASK_SET = 2;
  localparam int IDX_MASK_CLR = 3;
  localparam int IDX_SOFT_SET = 4;
  localparam int IDX_SOFT_CLR = 5;
  localparam int IDX_PT_SET   = 8;
  localparam int IDX_PT_CLR   = 9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N-1:0]      req_wdata,
  output logic [N-1:0]      rsp_rdata,
  output logic              bus_err,
  output logic [N-1:0]      eff_level,
  output logic [N-1:0]      en_mask,
  output logic [N-1:0]      pt_en
);
  localparam int IDX_W = ADDR_W - 2;

  logic [N-1:0]     lvl_q, mask_q, soft_q, pt_q;
  logic [N-1:0]     pt_allow;
  logic [IDX_W-1:0] idx;
  int               idx_i;
  logic             rd_req, wr_req, rd_hit, wr_hit;
  logic [N-1:0]     rd_val;
  logic [1:0]       unused_low;

  assign idx        = req_addr[ADDR_W-1:2];
  assign unused_low = req_addr[1:0];
  assign idx_i      = int'(idx);
  assign rd_req     = req_valid & ~req_write;
  assign wr_req     = req_valid & req_write;

  always_comb begin
    for (int i = 0; i < N; i++) pt_allow[i] = (i >= PT_LO) && (i <= PT_HI);
  end

  assign eff_level = lvl_q | soft_q;
  assign en_mask   = mask_q;
  assign pt_en     = pt_q;

  // Read decode
  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    case (idx_i)
      IDX_STATUS:   rd_val = eff_level & mask_q;
      IDX_RAW:      rd_val = eff_level;
      IDX_MASK_SET: rd_val = mask_q;
      IDX_SOFT_SET: rd_val = soft_q;
      IDX_PT_SET:   rd_val = pt_q;
      default:      rd_hit = 1'b0;
    endcase
  end

  // Write decode
  always_comb begin
    case (idx_i)
      IDX_MASK_SET, IDX_MASK_CLR, IDX_SOFT_SET,
      IDX_SOFT_CLR, IDX_PT_SET, IDX_PT_CLR: wr_hit = 1'b1;
      default:                              wr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      mask_q    <= '0;
      soft_q    <= '0;
      pt_q      <= '0;
      rsp_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      lvl_q     <= irq_in;
      rsp_rdata <= rd_req ? rd_val : '0;
      bus_err   <= (rd_req & ~rd_hit) | (wr_req & ~wr_hit);
      if (wr_req) begin
        case (idx_i)
          IDX_MASK_SET: mask_q <= mask_q | req_wdata;
          IDX_MASK_CLR: mask_q <= mask_q & ~req_wdata;
          IDX_SOFT_SET: soft_q <= soft_q | req_wdata;
          IDX_SOFT_CLR: soft_q <= soft_q & ~req_wdata;
          IDX_PT_SET:   pt_q   <= pt_q | (req_wdata & pt_allow);
          IDX_PT_CLR:   pt_q   <= pt_q & ~req_wdata;
          default: ;
        endcase
      end
    end
  end

  // R7: routing enables never escape the permitted range
  p_pt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_q & ~pt_allow) == '0);

  // R5: a mask-set write leaves all written bits set
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx_i == IDX_MASK_SET) |=> ((mask_q & $past(req_wdata)) == $past(req_wdata)));

  // R6: a soft-clear write leaves all written bits clear
  p_soft_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx_i == IDX_SOFT_CLR) |=> ((soft_q & $past(req_wdata)) == '0));

  // R8: a routing-clear write leaves all written bits clear
  p_pt_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx_i == IDX_PT_CLR) |=> ((pt_q & $past(req_wdata)) == '0));

  // R11: unmapped writes change no state; error only follows a request
  p_unmapped_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_hit) |=> ($stable(mask_q) && $stable(soft_q) && $stable(pt_q)));
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(req_valid));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N     = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  localparam int PT_N = PT_HI - PT_LO + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    eff_level,
  input  logic [N-1:0]    en_mask,
  input  logic [N-1:0]    pt_en,
  output logic            irq_combined,
  output logic [PT_N-1:0] irq_direct
);
  logic [PT_N-1:0] en_sub, lvl_sub;

  assign irq_combined = |(eff_level & en_mask);

  for (genvar k = 0; k < PT_N; k++) begin : g_direct
    assign en_sub[k]     = pt_en[PT_LO+k];
    assign lvl_sub[k]    = eff_level[PT_LO+k];
    assign irq_direct[k] = en_sub[k] & lvl_sub[k];
  end

  // R2: the combined request needs at least one enabled mask bit
  p_combined_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_combined |-> (en_mask != '0));

  // R9: a routed output is never high while its enable is clear
  p_direct_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_direct & ~en_sub) == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N      = 32,
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30,
  localparam int PT_N  = PT_HI - PT_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N-1:0]      req_wdata,
  output logic [N-1:0]      rsp_rdata,
  output logic              bus_err,
  output logic              irq_combined,
  output logic [PT_N-1:0]   irq_direct
);
  logic [N-1:0] eff_level, en_mask, pt_en;

  sic_regs #(.N(N), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .bus_err(bus_err),
    .eff_level(eff_level), .en_mask(en_mask), .pt_en(pt_en)
  );

  sic_route #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
    .clk(clk), .rst_n(rst_n), .eff_level(eff_level), .en_mask(en_mask),
    .pt_en(pt_en), .irq_combined(irq_combined), .irq_direct(irq_direct)
  );

  // R10: outputs quiet in the cycle after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_combined && irq_direct == '0 && !bus_err));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        bus_err;
  logic        irq_combined;
  logic [9:0]  irq_direct;

  always #10 clk = ~clk; // 50 MHz

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .bus_err(bus_err), .irq_combined(irq_combined),
    .irq_direct(irq_direct)
  );

  int n_total = 0;
  int n_pass  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // Monitor: pops expected read data when the registered response appears
  always @(posedge clk) rd_seen <= rst_n && req_valid && !req_write;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R4 unexpected read response", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] addr, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_irq(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 combined after reset", {31'b0, irq_combined}, 32'h0);
    check("R10 direct after reset", {22'b0, irq_direct}, 32'h0);
    check("R10 err after reset", {31'b0, bus_err}, 32'h0);
    bus_read(12'h000, 32'h0, "R10 status reset");
    bus_read(12'h008, 32'h0, "R10 mask reset");
    bus_read(12'h020, 32'h0, "R10 routing reset");

    // R1/R2/R4/R5: levels and mask
    set_irq(32'h0000_00A5);
    bus_read(12'h004, 32'h0000_00A5, "R1 raw level");
    check("R2 combined with zero mask", {31'b0, irq_combined}, 32'h0);
    bus_write(12'h008, 32'h0000_000F);
    check("R2 combined with mask", {31'b0, irq_combined}, 32'h1);
    bus_read(12'h000, 32'h0000_0005, "R4 masked status");
    bus_write(12'h00C, 32'h0000_0005);
    bus_read(12'h008, 32'h0000_000A, "R5 mask after clear");
    check("R2 combined after mask clear", {31'b0, irq_combined}, 32'h0);

    // R6: software bits
    bus_write(12'h010, 32'h0000_0002);
    bus_read(12'h010, 32'h0000_0002, "R6 soft readback");
    bus_read(12'h000, 32'h0000_0002, "R6 soft in status");
    check("R6 soft drives combined", {31'b0, irq_combined}, 32'h1);
    bus_write(12'h014, 32'h0000_0002);
    check("R6 combined after soft clear", {31'b0, irq_combined}, 32'h0);
    bus_read(12'h004, 32'h0000_00A5, "R6 raw after soft clear");

    // R3: low address bits ignored
    bus_write(12'h00B, 32'h0000_0100);
    bus_read(12'h00A, 32'h0000_010A, "R3 aliased mask access");

    // R9/R7/R8: routing
    set_irq(32'h4020_0000);
    check("R9 direct low while disabled", {22'b0, irq_direct}, 32'h0);
    bus_write(12'h020, 32'hFFFF_FFFF);
    check("R9 direct after enable", {22'b0, irq_direct}, 32'h201);
    bus_read(12'h020, 32'h7FE0_0000, "R7 routing range filter");
    bus_write(12'h024, 32'h0020_0000);
    bus_read(12'h020, 32'h7FC0_0000, "R8 routing after clear");
    check("R8 direct after clear", {22'b0, irq_direct}, 32'h200);
    bus_write(12'h010, 32'h0040_0000);
    check("R9 soft bit routed", {22'b0, irq_direct}, 32'h202);
    bus_write(12'h014, 32'h0040_0000);
    set_irq(32'h0000_0000);
    check("R9 direct follows level", {22'b0, irq_direct}, 32'h0);

    // R11: unmapped access
    bus_read(12'h018, 32'h0, "R11 unmapped read data");
    check("R11 err after unmapped read", {31'b0, bus_err}, 32'h1);
    @(negedge clk);
    check("R11 err single pulse", {31'b0, bus_err}, 32'h0);
    bus_read(12'h00C, 32'h0, "R11 write-only read data");
    check("R11 err on write-only read", {31'b0, bus_err}, 32'h1);
    bus_write(12'h01C, 32'hFFFF_FFFF);
    check("R11 err after unmapped write", {31'b0, bus_err}, 32'h1);
    bus_read(12'h008, 32'h0000_010A, "R11 mask untouched");
    check("R11 no err on mapped read", {31'b0, bus_err}, 32'h0);
    bus_read(12'h010, 32'h0, "R11 soft untouched");
    bus_read(12'h020, 32'h7FC0_0000, "R11 routing untouched");

    // R10: reset clears state again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(12'h008, 32'h0, "R10 mask cleared by reset");
    bus_read(12'h020, 32'h0, "R10 routing cleared by reset");
    repeat (2) @(negedge clk);
    check("R4 all responses consumed", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule